// File: doc/BRIEF.md
# Two-Wire Bus Slave with Type-Code Addressing

This block is the slave end of a two-wire serial bus. A fast system clock oversamples the bus. SCL and SDA each pass through a small synchroniser, and start, stop and clock edges are taken from the synchronised copies. Each transaction opens with a start and an address byte. The byte must carry the fixed device-type nibble 0101 in its upper half and the four strap inputs in its lower half; up to sixteen such slaves can therefore share one bus.

After a matching address the slave acknowledges a command byte. It hands that byte to a register bank with a one-cycle strobe. If the command asks for a write, one data byte follows, is acknowledged and is handed over with its own strobe. If the command asks for a read, the slave fetches a byte from the bank and shifts it out MSB first. It keeps fetching bytes as long as the master acknowledges them.

SDA is driven open drain: the block only ever enables a pull-low. Framing, address compare, acknowledge generation and byte handoff are all the block does. Command decoding is left to the register bank.

Top module: `twowire_slave`

## Requirements
- R1: A start (SDA falls while SCL is high) begins address reception. Until the first start, bus activity produces no acknowledge and no strobe.
- R2: The address byte is received MSB first. It is acknowledged only when it equals {4'b0101, strap_i[3:0]}.
- R3: After a non-matching address the slave keeps SDA released and gives no strobe until the next start.
- R4: To acknowledge, the slave pulls SDA low from the SCL falling edge after the eighth bit of a byte until the SCL falling edge after the ninth bit. It never changes its SDA drive while the synchronised SCL is high.
- R5: The byte after the address is the command. It is acknowledged, and cmd_stb_o pulses for one cycle while rx_byte_o holds the byte.
- R6: If command bit 0 is 0, one data byte follows. It is acknowledged, and data_stb_o pulses while rx_byte_o holds it. Any further byte before the next start is not acknowledged.
- R7: If command bit 0 is 1, rd_stb_o pulses on the SCL falling edge that ends the command acknowledge. rd_byte_i is captured in that cycle, and its MSB is driven at once. The remaining bits follow on each later falling edge.
- R8: After a read byte the slave releases SDA. A master acknowledge (SDA low on the ninth clock) fetches the next byte, with another rd_stb_o pulse. A not-acknowledge ends the read, and SDA then stays released until the next start.
- R9: A start at any point restarts address reception. A stop (SDA rises while SCL is high) returns the slave to idle from any state.
- R10: During and just after reset, SDA is released and all strobes are low.
- R11: At most one of cmd_stb_o, data_stb_o and rd_stb_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin |
| strap_i | input | 4 | Address strap pins, low nibble of the slave address |
| rd_byte_i | input | 8 | Byte offered by the register bank for reading |
| sda_oe_o | output | 1 | Pull SDA low when high (open drain) |
| rx_byte_o | output | 8 | Last command or data byte received |
| cmd_stb_o | output | 1 | One-cycle pulse: command byte valid on rx_byte_o |
| data_stb_o | output | 1 | One-cycle pulse: data byte valid on rx_byte_o |
| rd_stb_o | output | 1 | One-cycle pulse: rd_byte_i taken for transmission |

## Verification
The end of the command acknowledge and the start of a read both fall on one SCL falling edge. In that single system cycle the slave releases its acknowledge, captures rd_byte_i, pulses rd_stb_o and sets the drive for the first read bit. The bench provokes this with read bytes whose MSB is 0 and with read bytes whose MSB is 1. With MSB 0, SDA has to stay low straight from the acknowledge into bit 7. With MSB 1, SDA must be let go on the same edge. A behavioural master samples SDA in the middle of every SCL high phase. A queue of expected strobes, built from the transactions the bench issues, judges every system clock.

// File: rtl/twowire_slave.sv
module twowire_slave #(
  parameter logic [3:0] TYPE_CODE   = 4'b0101,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [3:0] strap_i,
  input  logic [7:0] rd_byte_i,
  output logic       sda_oe_o,
  output logic [7:0] rx_byte_o,
  output logic       cmd_stb_o,
  output logic       data_stb_o,
  output logic       rd_stb_o
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_DATA, S_TX, S_DONE} st_t;

  logic [SYNC_STAGES-1:0] scl_sy, sda_sy;
  logic scl_q, sda_q;
  logic scl_s, sda_s;
  st_t  st;
  logic [3:0] cnt;
  logic [7:0] sr, tx;
  logic ackph, mack, rdmode;

  assign scl_s = scl_sy[SYNC_STAGES-1];
  assign sda_s = sda_sy[SYNC_STAGES-1];

  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start    = scl_s & scl_q & sda_q & ~sda_s;
  wire stop     = scl_s & scl_q & ~sda_q & sda_s;
  wire addr_hit = (sr == {TYPE_CODE, strap_i});

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin scl_sy <= '1; sda_sy <= '1; end
        else begin scl_sy <= scl_i; sda_sy <= sda_i; end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin scl_sy <= '1; sda_sy <= '1; end
        else begin
          scl_sy <= {scl_sy[SYNC_STAGES-2:0], scl_i};
          sda_sy <= {sda_sy[SYNC_STAGES-2:0], sda_i};
        end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1; sda_q <= 1'b1;
      st <= S_IDLE; cnt <= '0; sr <= '0; tx <= '0;
      ackph <= 1'b0; mack <= 1'b0; rdmode <= 1'b0;
      sda_oe_o <= 1'b0; rx_byte_o <= '0;
      cmd_stb_o <= 1'b0; data_stb_o <= 1'b0; rd_stb_o <= 1'b0;
    end else begin
      scl_q <= scl_s; sda_q <= sda_s;
      cmd_stb_o <= 1'b0; data_stb_o <= 1'b0; rd_stb_o <= 1'b0;
      if (start) begin
        st <= S_ADDR; cnt <= '0; ackph <= 1'b0; sda_oe_o <= 1'b0;
      end else if (stop) begin
        st <= S_IDLE; ackph <= 1'b0; sda_oe_o <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_CMD, S_DATA: begin
            if (!ackph) begin
              if (scl_rise) begin
                sr  <= {sr[6:0], sda_s};
                cnt <= cnt + 4'd1;
              end else if (scl_fall && cnt == 4'd8) begin
                if (st == S_ADDR && !addr_hit) st <= S_DONE;
                else begin
                  ackph <= 1'b1; sda_oe_o <= 1'b1;
                  if (st == S_CMD)  begin rx_byte_o <= sr; cmd_stb_o <= 1'b1; rdmode <= sr[0]; end
                  if (st == S_DATA) begin rx_byte_o <= sr; data_stb_o <= 1'b1; end
                end
              end
            end else if (scl_fall) begin
              ackph <= 1'b0; cnt <= '0; sda_oe_o <= 1'b0;
              case (st)
                S_ADDR: st <= S_CMD;
                S_CMD:
                  if (rdmode) begin
                    st <= S_TX; tx <= rd_byte_i; sda_oe_o <= ~rd_byte_i[7];
                    cnt <= 4'd1; rd_stb_o <= 1'b1;
                  end else st <= S_DATA;
                default: st <= S_DONE;
              endcase
            end
          end
          S_TX: begin
            if (!ackph) begin
              if (scl_fall) begin
                if (cnt == 4'd8) begin
                  sda_oe_o <= 1'b0; ackph <= 1'b1;
                end else begin
                  sda_oe_o <= ~tx[6]; tx <= {tx[6:0], 1'b0}; cnt <= cnt + 4'd1;
                end
              end
            end else if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              ackph <= 1'b0;
              if (mack) begin
                tx <= rd_byte_i; sda_oe_o <= ~rd_byte_i[7]; cnt <= 4'd1; rd_stb_o <= 1'b1;
              end else st <= S_DONE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_stb_o, data_stb_o, rd_stb_o}));

  a_r4_drive_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe_o) && !$past(start) && !$past(stop)) |-> !$past(scl_s));

  a_r3_done_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE || st == S_IDLE) |-> !sda_oe_o);

  a_r2_ack_only_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR && ackph) |-> addr_hit);

  a_r5_cmd_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb_o |-> (st == S_CMD && sda_oe_o));

  a_r6_data_in_data_state: assert property (@(posedge clk) disable iff (!rst_n)
    data_stb_o |-> (st == S_DATA && sda_oe_o));

  a_r7_fetch_in_tx: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_o |-> (st == S_TX && $past(scl_fall)));

endmodule

// File: tb/sim_twowire_slave.sv
module sim_twowire_slave;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [3:0] strap = 4'hA;
  logic [7:0] rd_val = 8'h00;
  logic sda_oe, cmd_stb, data_stb, rd_stb;
  logic [7:0] rx_byte;
  wire sda_bus = m_sda & ~sda_oe;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [9:0] exp_q[$];
  logic [7:0] rd_list[$];

  always #10 clk = ~clk;

  twowire_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .strap_i(strap),
    .rd_byte_i(rd_val), .sda_oe_o(sda_oe), .rx_byte_o(rx_byte),
    .cmd_stb_o(cmd_stb), .data_stb_o(data_stb), .rd_stb_o(rd_stb));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done && (cmd_stb || data_stb || rd_stb)) begin
      logic [1:0] k;
      logic [9:0] e;
      k = cmd_stb ? 2'd0 : (data_stb ? 2'd1 : 2'd2);
      chk($countones({cmd_stb, data_stb, rd_stb}) == 1, "R11 single strobe",
          {cmd_stb, data_stb, rd_stb}, 0);
      if (exp_q.size() == 0) chk(0, "R3/R6/R8 unexpected strobe", k, 3);
      else begin
        e = exp_q.pop_front();
        if (k == 2'd2) chk(e[9:8] == 2'd2, "R7/R8 fetch strobe", k, e[9:8]);
        else chk(e == {k, rx_byte}, k == 0 ? "R5 command strobe" : "R6 data strobe",
                 {k, rx_byte}, e);
      end
      if (rd_stb) rd_val = (rd_list.size() != 0) ? rd_list.pop_front() : 8'h00;
    end
  end

  task automatic m_start();
    m_sda = 1'b1; wt(H); m_scl = 1'b1; wt(H); m_sda = 1'b0; wt(H); m_scl = 1'b0;
  endtask

  task automatic m_stop();
    m_sda = 1'b0; wt(H); m_scl = 1'b1; wt(H); m_sda = 1'b1; wt(H);
  endtask

  task automatic m_bit(input bit b, input string req);
    m_sda = b; wt(H); m_scl = 1'b1; wt(H/2);
    chk(sda_bus == b, req, sda_bus, b);
    wt(H/2); m_scl = 1'b0;
  endtask

  task automatic m_wbyte(input logic [7:0] b, input bit exp_ack, input string req);
    for (int i = 7; i >= 0; i--) m_bit(b[i], {req, " bus free during bits"});
    m_sda = 1'b1; wt(H); m_scl = 1'b1; wt(H/2);
    chk(!sda_bus == exp_ack, {req, " ack"}, !sda_bus, exp_ack);
    wt(H/2); m_scl = 1'b0;
  endtask

  task automatic m_rbyte(input logic [7:0] exp, input bit ack, input string req);
    logic [7:0] got;
    got = '0;
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wt(H); m_scl = 1'b1; wt(H/2); got = {got[6:0], sda_bus}; wt(H/2); m_scl = 1'b0;
    end
    chk(got == exp, req, got, exp);
    m_sda = !ack; wt(H); m_scl = 1'b1; wt(H); m_scl = 1'b0;
    m_sda = 1'b1;
  endtask

  initial begin
    wt(5);
    chk(!sda_oe && !cmd_stb && !data_stb && !rd_stb, "R10 reset outputs", sda_oe, 0);
    rst_n = 1'b1;
    wt(4);
    chk(!sda_oe && !cmd_stb && !data_stb && !rd_stb, "R10 after reset", sda_oe, 0);

    // R1: traffic before any start is ignored
    m_scl = 1'b0; wt(H);
    m_wbyte(8'h5A, 0, "R1 no start");

    // R2 R5 R6: full write
    m_start();
    m_wbyte(8'h5A, 1, "R2 address match");
    exp_q.push_back({2'd0, 8'h34});
    m_wbyte(8'h34, 1, "R5 command");
    exp_q.push_back({2'd1, 8'hA7});
    m_wbyte(8'hA7, 1, "R6 data");
    m_wbyte(8'h11, 0, "R6 extra byte");
    m_stop();

    // R3: wrong type code, then wrong strap
    m_start();
    m_wbyte(8'h7A, 0, "R3 wrong type");
    m_wbyte(8'h34, 0, "R3 ignored after miss");
    m_stop();
    m_start();
    m_wbyte(8'h5B, 0, "R2 wrong strap");
    m_stop();

    // R7 R8: read, first byte MSB 0, then MSB 1, then nack
    rd_val = 8'h3C; rd_list.push_back(8'hC3); rd_list.push_back(8'h00);
    m_start();
    m_wbyte(8'h5A, 1, "R2 address for read");
    exp_q.push_back({2'd0, 8'h81});
    exp_q.push_back({2'd2, 8'h00});
    m_wbyte(8'h81, 1, "R5 read command");
    exp_q.push_back({2'd2, 8'h00});
    m_rbyte(8'h3C, 1, "R7 first read byte");
    m_rbyte(8'hC3, 0, "R8 second read byte");
    m_wbyte(8'h00, 0, "R8 released after nack");
    m_stop();

    // R7: read starting with MSB 1
    rd_val = 8'hE5;
    m_start();
    m_wbyte(8'h5A, 1, "R2 address for read 2");
    exp_q.push_back({2'd0, 8'hFF});
    exp_q.push_back({2'd2, 8'h00});
    m_wbyte(8'hFF, 1, "R5 read command 2");
    m_rbyte(8'hE5, 0, "R7 read byte msb1");
    m_stop();

    // R9: repeated start restarts address reception
    m_start();
    m_wbyte(8'h5A, 1, "R9 first address");
    exp_q.push_back({2'd0, 8'h34});
    m_wbyte(8'h34, 1, "R9 first command");
    m_start();
    m_wbyte(8'h5A, 1, "R9 address after restart");
    exp_q.push_back({2'd0, 8'h56});
    m_wbyte(8'h56, 1, "R9 command after restart");
    exp_q.push_back({2'd1, 8'h99});
    m_wbyte(8'h99, 1, "R9 data after restart");
    m_stop();

    // R9: stop in the middle of an address, then no start
    m_start();
    m_bit(1'b0, "R9 partial"); m_bit(1'b1, "R9 partial");
    m_bit(1'b0, "R9 partial"); m_bit(1'b1, "R9 partial");
    m_stop();
    m_scl = 1'b0; wt(H);
    m_wbyte(8'h5A, 0, "R9 idle after stop");

    // R2: other strap value
    strap = 4'h3;
    m_start();
    m_wbyte(8'h5A, 0, "R2 old strap rejected");
    m_start();
    m_wbyte(8'h53, 1, "R2 new strap");
    exp_q.push_back({2'd0, 8'h20});
    m_wbyte(8'h20, 1, "R5 command new strap");
    exp_q.push_back({2'd1, 8'h01});
    m_wbyte(8'h01, 1, "R6 data new strap");
    m_stop();

    wt(10);
    chk(exp_q.size() == 0, "R5/R6/R7 all strobes seen", exp_q.size(), 0);
    chk(!sda_oe, "R9 idle released", sda_oe, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule